// File: doc/BRIEF.md
# Rounding shift and offset corrector

This block takes the raw signed result that a sigma-delta filter integrator produces for one channel and turns it into a 24-bit signed sample. Each incoming 32-bit word is first scaled down by an arithmetic right shift of 0 to 31 positions, rounded to the nearest integer. A signed 24-bit calibration offset is then added, and the sum is clamped to the 24-bit signed range. The corrected sample comes out one clock after the input, together with a one-cycle valid strobe.

Software sets the offset and the shift through two write ports. The offset may be rewritten at any time. A shift write is accepted only while the channel enable input is low, so the scaling cannot change while the channel is converting.

Top module: `rshift_ofs_corr`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` is 0, and both the offset and the shift are 0. The first samples after reset therefore pass through unchanged when they fit in 24 bits.
- R2: Each cycle with `in_valid` high produces `out_valid` high in the next cycle, and only then. `out_data` holds its last value while `out_valid` is low.
- R3: With a shift of 0 and an offset of 0, a sample in the range -2^23 to 2^23-1 appears unchanged on `out_data`.
- R4: With a nonzero shift s, the shifted value is floor((x + 2^(s-1)) / 2^s) on signed values. Rounding is to the nearest integer, ties go toward positive infinity, and the sign is kept. Examples: x=3 with s=1 gives 2, x=-3 with s=1 gives -1, and x=-5 with s=2 gives -1.
- R5: The offset, taken as a 24-bit two's complement value, is added after the shift.
- R6: If the shifted value plus the offset falls outside -2^23..2^23-1, the output saturates to -8388608 (0x800000) or 8388607 (0x7FFFFF).
- R7: A write on `cfg_sh_we` while `chan_en` is high is ignored, and the shift keeps its value. A write while `chan_en` is low takes effect for the samples that follow.
- R8: An offset write is accepted whether or not the channel is enabled. A sample presented in the same cycle as the write still uses the old offset; samples from the next cycle on use the new one.
- R9: The full shift range works: with s=31, input 0x7FFFFFFF gives 1, 0x40000000 gives 1, 0x3FFFFFFF gives 0, and 0x80000000 gives -1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; while high, the shift cannot be changed |
| cfg_ofs_we | input | 1 | Write strobe for the calibration offset |
| cfg_ofs_data | input | 24 | Offset value to write (signed) |
| cfg_sh_we | input | 1 | Write strobe for the right-shift amount |
| cfg_sh_data | input | 5 | Shift amount to write, 0 to 31 |
| in_valid | input | 1 | Integrator sample valid |
| in_data | input | 32 | Integrator sample (signed) |
| out_valid | output | 1 | Corrected result valid, one cycle after `in_valid` |
| out_data | output | 24 | Corrected result (signed) |

## Verification
Pass-through samples with a zero shift show that the result path and the one-cycle latency are right before any arithmetic is applied. Small positive and negative values at exact half steps tell round-to-nearest apart from truncation, and also show which way ties go. Large inputs at shift 31 and at the 24-bit edges, combined with offsets of both signs, separate saturation from wrap-around and show that the offset is added after the shift. Configuration writes are placed in the same cycle as a sample, and shift writes are made while the channel is enabled, to expose when each setting takes effect.

// File: rtl/rshift_ofs_corr.sv
module rshift_ofs_corr #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 24,
  parameter int SH_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             cfg_ofs_we,
  input  logic [OUT_W-1:0] cfg_ofs_data,
  input  logic             cfg_sh_we,
  input  logic [SH_W-1:0]  cfg_sh_data,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  localparam int EXT_W = IN_W + 2;
  localparam logic signed [EXT_W-1:0] MAX_V =
    signed'({{(EXT_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}});
  localparam logic signed [EXT_W-1:0] MIN_V = -MAX_V - 1;

  logic [OUT_W-1:0]        ofs_q;
  logic [SH_W-1:0]         sh_q;
  logic signed [EXT_W-1:0] x_ext, rnd, shd, sum, sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
      sh_q  <= '0;
    end else begin
      if (cfg_ofs_we) ofs_q <= cfg_ofs_data;
      if (cfg_sh_we && !chan_en) sh_q <= cfg_sh_data;
    end
  end

  assign x_ext = signed'({{2{in_data[IN_W-1]}}, in_data});
  assign rnd   = (sh_q == '0) ? '0
               : signed'({{(EXT_W-1){1'b0}}, 1'b1} << (sh_q - 1'b1));
  assign shd   = (x_ext + rnd) >>> sh_q;
  assign sum   = shd + signed'({{(EXT_W-OUT_W){ofs_q[OUT_W-1]}}, ofs_q});
  assign sat   = (sum > MAX_V) ? MAX_V : (sum < MIN_V) ? MIN_V : sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= sat[OUT_W-1:0];
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  a_r7_shift_locked: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en |=> $stable(sh_q));
  a_r8_offset_taken: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ofs_we |=> ofs_q == $past(cfg_ofs_data));
  a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sh_q == '0 && ofs_q == '0 &&
     in_data[IN_W-1:OUT_W-1] inside {'0, '1})
    |=> out_data == $past(in_data[OUT_W-1:0]));
endmodule

// File: tb/rshift_ofs_corr_test.sv
module rshift_ofs_corr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b0;
  logic        cfg_ofs_we = 1'b0;
  logic [23:0] cfg_ofs_data = '0;
  logic        cfg_sh_we = 1'b0;
  logic [4:0]  cfg_sh_data = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [23:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int          m_ofs = 0;
  int          m_sh = 0;
  logic [23:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  rshift_ofs_corr uut (.*);

  function automatic logic [23:0] model(logic [31:0] x, int sh, int ofs);
    longint v = longint'(signed'(x));
    if (sh != 0) v = v + (longint'(1) << (sh - 1));
    v = v >>> sh;
    v = v + longint'(ofs);
    if (v > 8388607) v = 8388607;
    if (v < -8388608) v = -8388608;
    return v[23:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One sample with optional config writes in the same cycle.
  task automatic drive(string tag, logic [31:0] x, bit ow = 0, int ov = 0,
                       bit sw = 0, int sv = 0);
    @(negedge clk);
    in_valid = 1'b1; in_data = x;
    cfg_ofs_we = ow; cfg_ofs_data = ov[23:0];
    cfg_sh_we = sw; cfg_sh_data = sv[4:0];
    exp_q.push_back(model(x, m_sh, m_ofs));
    tag_q.push_back(tag);
    if (ow) m_ofs = int'(signed'(ov[23:0]));
    if (sw && !chan_en) m_sh = sv;
    @(negedge clk);
    in_valid = 1'b0; cfg_ofs_we = 1'b0; cfg_sh_we = 1'b0;
  endtask

  task automatic set_cfg(bit ow, int ov, bit sw, int sv);
    @(negedge clk);
    cfg_ofs_we = ow; cfg_ofs_data = ov[23:0];
    cfg_sh_we = sw; cfg_sh_data = sv[4:0];
    if (ow) m_ofs = int'(signed'(ov[23:0]));
    if (sw && !chan_en) m_sh = sv;
    @(negedge clk);
    cfg_ofs_we = 1'b0; cfg_sh_we = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) check("R2 unexpected out_valid", 1, 0);
      else check(tag_q.pop_front(), {8'h0, out_data}, {8'h0, exp_q.pop_front()});
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid reset", {31'h0, out_valid}, 0);
    check("R1 out_data reset", {8'h0, out_data}, 0);
    rst_n = 1'b1;
    drive("R1 zero config passthrough", 32'h0012_3456);
    drive("R3 negative passthrough", 32'hFFF0_0001);
    drive("R3 max positive passthrough", 32'h007F_FFFF);
    drive("R6 shift0 saturate high", 32'h0080_0000);
    drive("R6 shift0 saturate low", 32'hFF7F_FFFF);
    @(negedge clk);
    check("R2 no output without input", {31'h0, out_valid}, 0);
    check("R2 data held", {8'h0, out_data}, 32'h80_0000);
    set_cfg(0, 0, 1, 1);
    drive("R4 tie +3 s1 -> 2", 32'd3);
    drive("R4 tie -3 s1 -> -1", -32'sd3);
    set_cfg(0, 0, 1, 2);
    drive("R4 -5 s2 -> -1", -32'sd5);
    drive("R4 6 s2 -> 2", 32'd6);
    drive("R4 -6 s2 -> -1", -32'sd6);
    set_cfg(0, 0, 1, 8);
    drive("R4 s8 large", 32'h1234_5680);
    drive("R4 s8 negative", 32'hEDCB_A980);
    set_cfg(0, 0, 1, 31);
    drive("R9 s31 max", 32'h7FFF_FFFF);
    drive("R9 s31 tie", 32'h4000_0000);
    drive("R9 s31 below tie", 32'h3FFF_FFFF);
    drive("R9 s31 min", 32'h8000_0000);
    set_cfg(1, 1000, 1, 4);
    drive("R5 offset after shift", 32'd160);
    drive("R5 negative offset", 32'd160, 1, -2000);
    drive("R8 new offset applied", 32'd160);
    chan_en = 1'b1;
    drive("R7 locked write ignored same cycle", 32'd1600, 0, 0, 1, 0);
    drive("R7 shift still 4", 32'd1600);
    drive("R8 offset write while enabled", 32'd0, 1, 8388607);
    drive("R6 saturate high with offset", 32'h7FFF_FFF0);
    drive("R6 saturate low with offset", 32'h8000_0000, 1, -8388608);
    drive("R6 negative saturate", 32'h8000_0000);
    chan_en = 1'b0;
    set_cfg(1, 0, 1, 0);
    drive("R7 write accepted when disabled", 32'h0000_1234);
    repeat (4) @(negedge clk);
    check("R2 all results delivered", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule